// File: doc/BRIEF.md
# Phase-Frequency Detector with Selectable Pump Polarity

This block compares a reference pulse train, taken from a reference divider, against a feedback pulse train, taken from the divider on the oscillator side. It drives two pump controls whose high time tracks the phase error between the two trains. A fast sampling clock runs the logic, so widths are resolved to whole sampling cycles. The comparison rate may go up to 10 MHz, which sets how fast the sampling clock must be.

Each input has a latch of its own. A rising edge on the leading input raises its latch. The latch stays high until the other input's edge also arrives. The two latches then stay high together for a programmed number of cycles, and both drop at the same moment. This shared on-time gives the charge pump a short pulse from both sides even at zero error, which removes the dead zone. If the lagging edge never arrives, the leading latch stays high, so the block also acts as a frequency detector. A polarity input swaps the two pump outputs, for oscillators whose frequency falls as the tuning voltage rises.

A lock flag watches how closely the two latch widths match over a run of successive comparisons.

Top module: `phase_detector`

## Requirements
- R1: While reset is held, and on the first sampling cycle after it is released, pump_up, pump_dn and locked are all low.
- R2: A rising edge on ref_in raises the reference latch, and a rising edge on fb_in raises the feedback latch. With invert_pol = 0, the reference latch drives pump_up and the feedback latch drives pump_dn. A latch goes high on the first clock edge that samples its input high after a low sample.
- R3: When both latches are high, they stay high together for exactly overlap_cfg cycles. An overlap_cfg of 0 counts as 1. Both latches then clear on the same edge. So if the feedback edge lags the reference edge by d cycles, the reference latch is high for d + overlap_cfg cycles and the feedback latch is high for overlap_cfg cycles. The mirror case, where the reference edge lags, behaves the same way.
- R4: Edges that are sampled in the same cycle on both inputs give equal up and down pulses, each overlap_cfg cycles long.
- R5: With invert_pol = 1, the reference latch drives pump_dn and the feedback latch drives pump_up.
- R6: Further edges on the leading input do not end its latch while the other input's edge is missing. The latch stays high for as long as the lagging edge is absent, which gives frequency detection beyond a phase error of one full cycle.
- R7: Each joint clearing of the latches ends one comparison. A comparison is good when the two latch widths differ by at most one cycle. locked goes high in the cycle after the 8th good comparison in a row, and goes low in the cycle after the first comparison that is not good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on a clock edge inside the block |
| ref_in | input | 1 | Reference divider output |
| fb_in | input | 1 | Feedback divider output |
| invert_pol | input | 1 | 1 swaps the pump outputs |
| overlap_cfg | input | 3 | Joint on-time in cycles, 1 to 7 (0 is read as 1) |
| pump_up | output | 1 | Pump-up control |
| pump_dn | output | 1 | Pump-down control |
| locked | output | 1 | Width-match lock flag |

## Verification
The polarity assertion assumes that invert_pol does not change in a cycle where a latch rises. The bench therefore changes invert_pol and overlap_cfg only between comparisons, once both latches have cleared. The assertions also assume that ref_in and fb_in are synchronous to the sampling clock and stay high for at least one cycle. The bench drives each input pulse for exactly one cycle, on the falling clock edge, so every rising edge is seen by exactly one sample. Each comparison gets a 40-cycle window, which is longer than the largest pulse width used, so every pulse ends before the next window starts.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  typedef enum logic {PORT_REF = 1'b0, PORT_FB = 1'b1} pfd_port_e;

  typedef struct packed {
    logic up;
    logic dn;
  } pump_t;

  function automatic pump_t route_pumps(input logic ref_lat, input logic fb_lat,
                                        input logic swap);
    pump_t p;
    p.up = swap ? fb_lat  : ref_lat;
    p.dn = swap ? ref_lat : fb_lat;
    return p;
  endfunction
endpackage

// File: rtl/pfd_edge.sv
module pfd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_i,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise_o = sig_i & ~prev_q;
endmodule

// File: rtl/pfd_latches.sv
module pfd_latches #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_ref,
  input  logic          rise_fb,
  input  logic [CW-1:0] ovl_len,
  output logic          lat_ref,
  output logic          lat_fb,
  output logic          clr_o
);
  logic [CW-1:0] ovl_eff;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ref_d, fb_d;
  logic          both;

  always_comb begin
    ovl_eff = (ovl_len == '0) ? CW'(1) : ovl_len;
    both    = lat_ref & lat_fb;
    clr_o   = both & (cnt_q == ovl_eff - CW'(1));
    cnt_d   = cnt_q;
    if (clr_o)     cnt_d = '0;
    else if (both) cnt_d = cnt_q + CW'(1);
    ref_d = rise_ref | (lat_ref & ~clr_o);
    fb_d  = rise_fb  | (lat_fb  & ~clr_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_ref <= 1'b0;
      lat_fb  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      lat_ref <= ref_d;
      lat_fb  <= fb_d;
      cnt_q   <= cnt_d;
    end
  end

  // R3
  ovl_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_ref && lat_fb) |-> (cnt_q < ovl_eff));
  // R3
  joint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat_ref) |-> $past(lat_fb));
  // R2
  set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_ref) |-> $past(rise_ref));
  // R6
  hold_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_ref && !lat_fb && !rise_fb) |=> lat_ref);
endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int WCW    = 8,
  parameter int LOCK_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lat_ref,
  input  logic lat_fb,
  input  logic clr,
  output logic locked
);
  localparam int LCW = $clog2(LOCK_N + 1);
  localparam logic [WCW-1:0] WMAX = {WCW{1'b1}};

  logic [WCW-1:0] wr_q, wr_d, wf_q, wf_d, diff;
  logic [LCW-1:0] good_q, good_d;
  logic           good;

  always_comb begin
    diff = (wr_q > wf_q) ? (wr_q - wf_q) : (wf_q - wr_q);
    good = (diff <= WCW'(1));
    wr_d = wr_q;
    wf_d = wf_q;
    if (clr) begin
      wr_d = '0;
      wf_d = '0;
    end else begin
      if (lat_ref && wr_q != WMAX) wr_d = wr_q + WCW'(1);
      if (lat_fb  && wf_q != WMAX) wf_d = wf_q + WCW'(1);
    end
    good_d = good_q;
    if (clr) begin
      if (!good)                       good_d = '0;
      else if (good_q != LCW'(LOCK_N)) good_d = good_q + LCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= '0;
      wf_q   <= '0;
      good_q <= '0;
    end else begin
      wr_q   <= wr_d;
      wf_q   <= wf_d;
      good_q <= good_d;
    end
  end

  assign locked = (good_q == LCW'(LOCK_N));

  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(clr));
  // R7
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(clr));
endmodule

// File: rtl/phase_detector.sv
module phase_detector #(
  parameter int CW     = 3,
  parameter int WCW    = 8,
  parameter int LOCK_N = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ref_in,
  input  logic          fb_in,
  input  logic          invert_pol,
  input  logic [CW-1:0] overlap_cfg,
  output logic          pump_up,
  output logic          pump_dn,
  output logic          locked
);
  import pfd_pkg::*;

  localparam int NPORT = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [NPORT-1:0] sig_vec;
  logic [NPORT-1:0] rise_vec;
  logic             lat_ref, lat_fb, clr;
  pump_t            pumps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign sig_vec[PORT_REF] = ref_in;
  assign sig_vec[PORT_FB]  = fb_in;

  for (genvar g = 0; g < NPORT; g++) begin : g_edge
    pfd_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_int_n),
      .sig_i  (sig_vec[g]),
      .rise_o (rise_vec[g])
    );
  end

  pfd_latches #(.CW(CW)) u_lat (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .rise_ref (rise_vec[PORT_REF]),
    .rise_fb  (rise_vec[PORT_FB]),
    .ovl_len  (overlap_cfg),
    .lat_ref  (lat_ref),
    .lat_fb   (lat_fb),
    .clr_o    (clr)
  );

  pfd_lock #(.WCW(WCW), .LOCK_N(LOCK_N)) u_lock (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .lat_ref (lat_ref),
    .lat_fb  (lat_fb),
    .clr     (clr),
    .locked  (locked)
  );

  always_comb begin
    pumps   = route_pumps(lat_ref, lat_fb, invert_pol);
    pump_up = pumps.up;
    pump_dn = pumps.dn;
  end

  // R5
  polarity_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($stable(invert_pol) && $rose(pump_up)) |->
      (invert_pol ? $past(rise_vec[PORT_FB]) : $past(rise_vec[PORT_REF])));
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (!pump_up && !pump_dn && !locked));
endmodule

// File: tb/sim_phase_detector.sv
module sim_phase_detector;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_in, fb_in, invert_pol;
  logic [2:0] overlap_cfg;
  logic       pump_up, pump_dn, locked;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  phase_detector u0 (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
    .invert_pol(invert_pol), .overlap_cfg(overlap_cfg),
    .pump_up(pump_up), .pump_dn(pump_dn), .locked(locked)
  );

  // {invert, cfg, lag d (fb after ref, signed), expected up, dn, overlap}
  typedef struct packed {
    logic     inv;
    logic [2:0] cfg;
    int       d;
    int       up;
    int       dn;
    int       ov;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 3'd1,   3,  4,  1, 1},
    '{1'b0, 3'd2,   0,  2,  2, 2},
    '{1'b0, 3'd3,  -5,  3,  8, 3},
    '{1'b1, 3'd1,   3,  1,  4, 1},
    '{1'b1, 3'd4,  -2,  6,  4, 4},
    '{1'b0, 3'd7,   6, 13,  7, 7},
    '{1'b1, 3'd0,   0,  1,  1, 1},
    '{1'b0, 3'd5,  10, 15,  5, 5}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    ref_in = 0; fb_in = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic run_cmp(input int d, output int nu, output int nd, output int nov);
    int a = 2 + ((d < 0) ? -d : 0);
    int b = 2 + ((d > 0) ?  d : 0);
    nu = 0; nd = 0; nov = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      nu  += int'(pump_up);
      nd  += int'(pump_dn);
      nov += int'(pump_up && pump_dn);
      ref_in = (i == a);
      fb_in  = (i == b);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int nu, nd, nov;
    invert_pol = 0; overlap_cfg = 3'd2;
    ref_in = 0; fb_in = 0; rst_n = 0;
    repeat (2) @(negedge clk);
    // R1: outputs quiet during reset
    check("R1 up in reset", pump_up, 0);
    check("R1 dn in reset", pump_dn, 0);
    check("R1 lock in reset", locked, 0);
    do_reset();
    check("R1 outputs after release", {pump_up, pump_dn, locked}, 0);

    // R2 R3 R4 R5: vector table
    for (int k = 0; k < NV; k++) begin
      invert_pol  = VECS[k].inv;
      overlap_cfg = VECS[k].cfg;
      run_cmp(VECS[k].d, nu, nd, nov);
      check((VECS[k].d == 0) ? "R4 up width" : (VECS[k].inv ? "R5 up width" : "R2 up width"),
            nu, VECS[k].up);
      check((VECS[k].d == 0) ? "R4 dn width" : (VECS[k].inv ? "R5 dn width" : "R3 dn width"),
            nd, VECS[k].dn);
      check("R3 overlap width", nov, VECS[k].ov);
    end

    // R6: reference edges with no feedback keep pump_up high
    do_reset();
    invert_pol = 0; overlap_cfg = 3'd2;
    nu = 0; nd = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      nu += int'(pump_up);
      nd += int'(pump_dn);
      ref_in = (i == 2 || i == 12 || i == 22);
      fb_in  = 0;
    end
    check("R6 up held across extra edges", nu, 37);
    check("R6 dn stays low", nd, 0);

    // R7: lock after 8 good comparisons, drop on a bad one
    do_reset();
    invert_pol = 0; overlap_cfg = 3'd2;
    for (int k = 0; k < 7; k++) run_cmp((k % 3 == 0) ? 0 : ((k % 3 == 1) ? 1 : -1), nu, nd, nov);
    check("R7 not locked after 7", locked, 0);
    run_cmp(1, nu, nd, nov);
    check("R7 locked after 8", locked, 1);
    run_cmp(2, nu, nd, nov);
    check("R7 unlock on bad comparison", locked, 0);
    run_cmp(0, nu, nd, nov);
    check("R7 count restarts after bad", locked, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule